// File: doc/BRIEF.md
# I2C Control Register Port

This block is an I2C target that lets a host read and write a bank of 128 eight-bit control registers. The registers themselves sit in a separate register file. The port drives that file through a one-cycle write strobe with an address and data, and through a read address whose data comes back combinationally. The block samples SCL and SDA on its own system clock. It pulls SDA low through an open-drain enable and never stretches the clock.

A write transaction starts with the device address. It then carries a pointer byte, followed by zero or more data bytes. Bit 7 of the pointer byte selects auto-increment and bits 6:0 select the register. The pointer lives on after a stop. A host therefore reads a register by sending a write that holds only the pointer byte. It then either stops and starts again, or issues a repeated start, and sends the address with the read bit set. The target then sends the selected register, most significant bit first. When auto-increment is on, each data byte read or written moves the pointer to the next register.

Top module: `i2c_regport`

## Requirements
- R1: The target acknowledges an address byte whose upper five bits are 10011, whose next two bits equal `addr_sel`, and whose last bit is the direction (1 = read). It acknowledges by holding SDA low for the ninth clock.
- R2: If an address byte does not match, the target does not acknowledge it. It then leaves SDA released and issues no register write until the next start condition.
- R3: The first byte after a matching write address is the pointer byte. Bit 7 is the auto-increment flag and bits 6:0 are the register pointer. The target acknowledges it.
- R4: Each data byte after the pointer byte is acknowledged and produces exactly one single-cycle `reg_wr_en` pulse. The pulse carries the current pointer on `reg_wr_addr` and the byte on `reg_wr_data`.
- R5: With the flag set, each data byte that is written or read advances the pointer by one. The pointer wraps from 127 to 0.
- R6: With the flag clear, every data byte of a transaction uses the same register.
- R7: The pointer and flag survive a stop condition. A later transaction that opens with a read address returns the selected register, most significant bit first.
- R8: A repeated start after the pointer byte switches the transaction to a read of the selected register.
- R9: When the host does not acknowledge a read byte, the target releases SDA. It then drives nothing until a start or stop condition.
- R10: After reset, SDA is released, no write strobe is active, the pointer is 0 and auto-increment is off.
- R11: A start is an SDA fall while SCL is high, and a stop is an SDA rise while SCL is high. A start restarts address reception, even in the middle of a byte.
- R12: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_sel | input | 2 | Low two bits of the target address |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_wr_en | output | 1 | Single-cycle register write strobe |
| reg_wr_addr | output | 7 | Register index for the write |
| reg_wr_data | output | 8 | Data for the write |
| reg_rd_addr | output | 7 | Current pointer, used as the read index |
| reg_rd_data | input | 8 | Register file contents at `reg_rd_addr` |

## Verification
The bench aims at the pointer's life across transactions. It writes only a pointer byte, aborts with a stop, and then reads. A design that cleared the pointer on stop would return register 0. It also switches to a read through a repeated start. It drives the pointer from 127 up to 0, and it holds the flag clear while several bytes go to one register. A design with a broken wrap or a stray increment would write to the wrong index. That error shows up in a later read-back and in the per-clock write comparison. Foreign addresses, a start in the middle of a byte, and a host NACK followed by extra clocks all check that the target stays silent on SDA. A design that acknowledged stray bytes, or kept driving after a NACK, would pull the line low where the host expects it high.

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter logic [4:0] ADDR_HI = 5'b10011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel,
  output logic       sda_oe,
  output logic       reg_wr_en,
  output logic [6:0] reg_wr_addr,
  output logic [7:0] reg_wr_data,
  output logic [6:0] reg_rd_addr,
  input  logic [7:0] reg_rd_data
);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_PTR, S_DACK, S_WR, S_RD, S_RACK, S_WAIT
  } st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic [7:0] shreg;
  logic [3:0] cnt;
  logic [6:0] ptr;
  logic       inc, rw, nack, oe;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  wire scl_rise = scl_sy[1] & ~scl_q;
  wire scl_fall = ~scl_sy[1] & scl_q;
  wire start_c  = scl_sy[1] & scl_q & sda_q & ~sda_sy[1];
  wire stop_c   = scl_sy[1] & scl_q & ~sda_q & sda_sy[1];
  wire rx_state = (st == S_ADDR) || (st == S_PTR) || (st == S_WR);
  wire byte_in  = (cnt == 4'd8);

  assign sda_oe      = oe;
  assign reg_rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; shreg <= '0; cnt <= '0; ptr <= '0; inc <= 1'b0;
      rw <= 1'b0; nack <= 1'b0; oe <= 1'b0;
      reg_wr_en <= 1'b0; reg_wr_addr <= '0; reg_wr_data <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      if (start_c) begin
        st <= S_ADDR; cnt <= '0; oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; oe <= 1'b0;
      end else begin
        if (rx_state && scl_rise && !byte_in) begin
          shreg <= {shreg[6:0], sda_sy[1]};
          cnt   <= cnt + 4'd1;
        end
        case (st)
          S_ADDR:
            if (scl_fall && byte_in) begin
              if (shreg[7:1] == {ADDR_HI, addr_sel}) begin
                rw <= shreg[0]; oe <= 1'b1; st <= S_AACK;
              end else begin
                st <= S_WAIT;
              end
            end
          S_AACK:
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                shreg <= reg_rd_data; oe <= ~reg_rd_data[7]; st <= S_RD;
              end else begin
                oe <= 1'b0; st <= S_PTR;
              end
            end
          S_PTR:
            if (scl_fall && byte_in) begin
              ptr <= shreg[6:0]; inc <= shreg[7]; oe <= 1'b1; st <= S_DACK;
            end
          S_DACK:
            if (scl_fall) begin
              oe <= 1'b0; cnt <= '0; st <= S_WR;
            end
          S_WR:
            if (scl_fall && byte_in) begin
              reg_wr_en   <= 1'b1;
              reg_wr_addr <= ptr;
              reg_wr_data <= shreg;
              ptr         <= ptr + {6'd0, inc};
              oe          <= 1'b1;
              st          <= S_DACK;
            end
          S_RD: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            if (scl_fall) begin
              if (byte_in) begin
                oe <= 1'b0; ptr <= ptr + {6'd0, inc}; st <= S_RACK;
              end else begin
                shreg <= {shreg[6:0], 1'b0}; oe <= ~shreg[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) nack <= sda_sy[1];
            if (scl_fall) begin
              cnt <= '0;
              if (nack) begin
                st <= S_WAIT;
              end else begin
                shreg <= reg_rd_data; oe <= ~reg_rd_data[7]; st <= S_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end

  p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  p_wr_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> sda_oe);

  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_q);

  p_mismatch_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_ADDR && st == S_WAIT) |-> (!sda_oe && !reg_wr_en));

  p_ptr_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_PTR && !inc) |=> $stable(reg_rd_addr));

  p_nack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |=> !sda_oe);

endmodule

// File: tb/i2c_regport_tb.sv
module i2c_regport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] sel = 2'b01;
  logic sda_oe, reg_wr_en;
  logic [6:0] reg_wr_addr, reg_rd_addr;
  logic [7:0] reg_wr_data, reg_rd_data;
  logic [7:0] regs [128];
  logic [7:0] mdl [128];
  logic [14:0] exp_q [$];
  logic [14:0] e;
  logic oe_prev = 1'b0;
  int vectors = 0, fails = 0;
  int m_ptr = 0;
  bit m_inc = 1'b0;

  wire sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regport u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(sel), .sda_oe(sda_oe), .reg_wr_en(reg_wr_en),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  always @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) regs[i] <= 8'(i * 7 + 3);
    end else if (reg_wr_en) begin
      regs[reg_wr_addr] <= reg_wr_data;
    end
  assign reg_rd_data = regs[reg_rd_addr];

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n) begin
      chk(!(sda_oe != oe_prev && scl_m), "R12 drive change while SCL high", sda_oe, oe_prev);
      oe_prev <= sda_oe;
      if (reg_wr_en) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4 unexpected write", {reg_wr_addr, reg_wr_data}, 0);
        end else begin
          e = exp_q.pop_front();
          chk({reg_wr_addr, reg_wr_data} == e, "R4 write addr/data",
              {reg_wr_addr, reg_wr_data}, e);
        end
      end
    end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    acked = !b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(!give_ack);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic addr(input logic rw, input logic [1:0] s, input bit exp_ack, input string r);
    logic a;
    send_byte({5'b10011, s, rw}, a);
    chk(a == exp_ack, r, a, exp_ack);
  endtask

  task automatic put_ptr(input logic [7:0] p);
    logic a;
    send_byte(p, a);
    chk(a, "R3 pointer byte ack", a, 1);
    m_ptr = p[6:0]; m_inc = p[7];
  endtask

  task automatic put_data(input logic [7:0] d, input string r);
    logic a;
    exp_q.push_back({7'(m_ptr), d});
    mdl[m_ptr] = d;
    send_byte(d, a);
    chk(a, {r, " data ack"}, a, 1);
    if (m_inc) m_ptr = (m_ptr + 1) % 128;
  endtask

  task automatic get_data(input logic give_ack, input string r);
    logic [7:0] d;
    recv_byte(give_ack, d);
    chk(d == mdl[m_ptr], r, d, mdl[m_ptr]);
    if (m_inc) m_ptr = (m_ptr + 1) % 128;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic a, b;
    for (int i = 0; i < 128; i++) mdl[i] = 8'(i * 7 + 3);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 SDA released", sda_oe, 0);
    chk(reg_wr_en == 1'b0, "R10 no strobe", reg_wr_en, 0);
    chk(reg_rd_addr == 7'd0, "R10 pointer zero", reg_rd_addr, 0);

    // R10 / R1 / R9: read at reset pointer, NACK, then silence
    start_c(); addr(1'b1, sel, 1'b1, "R1 read address ack");
    get_data(1'b0, "R10 read at pointer 0");
    for (int i = 0; i < 9; i++) begin
      bit_in(b);
      chk(b == 1'b1, "R9 released after NACK", b, 1);
    end
    stop_c();

    // R3 R4 R5: incrementing write
    start_c(); addr(1'b0, sel, 1'b1, "R1 write address ack");
    put_ptr(8'h85);
    put_data(8'hA1, "R5"); put_data(8'hB2, "R5"); put_data(8'hC3, "R5");
    stop_c();

    // R6: fixed pointer
    start_c(); addr(1'b0, sel, 1'b1, "R1 write address ack");
    put_ptr(8'h10);
    put_data(8'h11, "R6"); put_data(8'h22, "R6");
    stop_c();

    // R7: pointer-only write aborted by stop, then read sequence
    start_c(); addr(1'b0, sel, 1'b1, "R1 write address ack");
    put_ptr(8'h85); stop_c();
    start_c(); addr(1'b1, sel, 1'b1, "R7 read address ack");
    get_data(1'b1, "R7 read reg 5"); get_data(1'b1, "R5 read reg 6");
    get_data(1'b0, "R5 read reg 7");
    stop_c();

    // R8: repeated start, flag clear
    start_c(); addr(1'b0, sel, 1'b1, "R1 write address ack");
    put_ptr(8'h10);
    start_c(); addr(1'b1, sel, 1'b1, "R8 read after repeated start");
    get_data(1'b1, "R8 read reg 0x10"); get_data(1'b0, "R6 same reg again");
    stop_c();

    // R1 with another select, R2 foreign addresses
    sel = 2'b10;
    start_c(); addr(1'b0, 2'b01, 1'b0, "R2 wrong low bits not acked");
    send_byte(8'h55, a); chk(!a, "R2 ignored data not acked", a, 0);
    stop_c();
    start_c(); send_byte(8'b1011_0100, a); chk(!a, "R2 wrong upper bits", a, 0);
    send_byte(8'h33, a); chk(!a, "R2 ignored data not acked", a, 0);
    // R11: start after ignored address resumes matching
    start_c(); addr(1'b0, 2'b10, 1'b1, "R11 start after mismatch");
    // R5: wrap from 127 to 0
    put_ptr(8'hFF);
    put_data(8'h5A, "R5 wrap"); put_data(8'h6B, "R5 wrap");
    stop_c();
    start_c(); addr(1'b0, 2'b10, 1'b1, "R1 write address ack");
    put_ptr(8'hFF);
    start_c(); addr(1'b1, 2'b10, 1'b1, "R8 read address ack");
    get_data(1'b1, "R5 read reg 127"); get_data(1'b0, "R5 wrapped read reg 0");
    stop_c();

    // R11: start in the middle of a byte
    start_c(); bit_out(1'b1); bit_out(1'b0); bit_out(1'b0); bit_out(1'b1);
    start_c(); addr(1'b1, 2'b10, 1'b1, "R11 mid-byte restart ack");
    get_data(1'b0, "R11 read after restart");
    stop_c();

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
    chk(sda_oe == 1'b0, "R9 idle released", sda_oe, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule